// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives one open-drain, single-wire serial bus on behalf of software. A small register file lets software issue a bus reset and learn whether a slave answered with a presence pulse. It also lets software hand over bytes for serial transmission. Each byte is sent least significant bit first as a series of fixed-length time slots. A one bit is a short low pulse and a zero bit a long one. The line is sampled inside every slot, so each byte sent is also a byte received. Sending all ones reads a byte from a slave that pulls the line low for its zero bits.

All slot timing is counted in base units. A base unit is the system clock divided by a programmable divisor. Software can also hold the line low directly, read back the current synchronised line level, and latch a search-mode flag that only reads back. The pin is modelled as a drive-low enable plus a sampled input. Status flags can raise a single interrupt, gated bit by bit by an enable register.

Top module: `owire_master`

## Requirements
- R1: After reset the status register reads 0x0C (transmit buffer empty, shift register empty), the enable register reads 0, the divisor reads its reset parameter (1), the command register reads 0x08 with the bus idle high, the line is released and irq is low.
- R2: One base unit lasts divisor+1 clock cycles, and the unit timers restart whenever a reset sequence or a byte begins, so with divisor 3 a reset holds the line low for exactly 1920 cycles.
- R3: Writing 1 to command bit 0 begins a reset one cycle after the write. The line is held low for 480 units and then released for 480 units (70 to the presence sample, then 410 more). Command bit 0 reads 1 from the write until the sequence ends.
- R4: Presence is sampled 70 units after release. At the end of the sequence status bit 0 (presence phase done) is set and status bit 1 holds 1 if the line was low at the sample, else 0. Reading the status register (address 2) clears bit 0.
- R5: A byte is sent LSB first in slots of 70 units each, with no gap between the bits of one byte. A 1 bit holds the line low for 6 units and a 0 bit for 60 units, then the line is released for the rest of the slot. A byte waiting in the buffer starts one cycle after the previous byte ends.
- R6: A data write (address 1) clears status bit 2 (buffer empty) on the next cycle. On the following cycle the byte moves into the idle shift register, which sets bit 2 again and clears status bit 3 (shift register empty). Bit 3 is set again when the eighth slot ends.
- R7: The line is sampled 15 units into each slot. After the eighth slot the assembled byte (first bit in bit 0) goes to the receive buffer and status bit 4 is set. A data read returns that byte and clears bit 4.
- R8: irq is high exactly when some status bit and the enable bit at the same position (address 3, bits 4..0) are both set.
- R9: While command bit 2 is 1 the line is driven low, from the cycle after the write. The bit always reads back as 0.
- R10: Command bit 3 returns the line level through one register stage, one clock cycle behind the pin.
- R11: Command bit 1 is stored and reads back, and has no effect on the line.
- R12: The register map is command 0, data 1, status 2, enable 3, divisor 4. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears read-sensitive flags) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Enabled-status interrupt |
| dq_in | input | 1 | Sampled level of the bus line |
| dq_drive_low | output | 1 | When high, the open-drain driver pulls the line low |

## Verification
Results arrive on fixed cycles. A reset or a queued byte starts driving the line on the second clock edge after the write. A data write clears the buffer-empty flag one edge later, and the move into the shift register shows one edge after that. The synchronised line level in command bit 3 lags the pin by one edge. The bench models the expected line as a queue of per-cycle levels, built from the unit counts and the divisor, and checks it on every falling clock edge. Register reads are taken at falling edges counted against those edge positions, including back-to-back reads that catch each one-cycle step.

// File: rtl/owire_master.sv
`timescale 1ns/1ps
module owire_master #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int DIV_W     = 8,
  parameter int DIV_INIT  = 1,
  parameter int RST_LOW   = 480,
  parameter int PD_AT     = 70,
  parameter int RST_TAIL  = 410,
  parameter int W1_LOW    = 6,
  parameter int W0_LOW    = 60,
  parameter int RECOVER   = 10,
  parameter int SAMPLE_AT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              dq_in,
  output logic              dq_drive_low
);
  localparam int RST_LEN  = RST_LOW + PD_AT + RST_TAIL;
  localparam int SLOT_LEN = W0_LOW + RECOVER;
  localparam int UCNT_W   = $clog2(RST_LEN + 1);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int NFLAG    = 5;
  localparam logic [ADDR_W-1:0] A_CMD = 0, A_DATA = 1, A_STAT = 2, A_IEN = 3, A_DIV = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RST, ST_SLOT} st_t;

  st_t               st;
  logic [DIV_W-1:0]  div_q, dcnt;
  logic [UCNT_W-1:0] ucnt, low_units;
  logic              tick;
  logic              rst_pend, sra, force_lo, dq_s, smp;
  logic              pd, pdr, tbe, temt, rbf;
  logic [DATA_W-1:0] txbuf, shreg, rxsh, rxbuf;
  logic [BIT_W-1:0]  bitn;
  logic [NFLAG-1:0]  ien, stat;

  wire wr_cmd  = bus_wr && bus_addr == A_CMD;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire wr_ien  = bus_wr && bus_addr == A_IEN;
  wire wr_div  = bus_wr && bus_addr == A_DIV;
  wire rd_data = bus_rd && bus_addr == A_DATA;
  wire rd_stat = bus_rd && bus_addr == A_STAT;

  assign tick      = dcnt >= div_q;
  assign stat      = {rbf, temt, tbe, pdr, pd};
  assign irq       = |(stat & ien);
  assign low_units = shreg[0] ? UCNT_W'(W1_LOW) : UCNT_W'(W0_LOW);
  assign dq_drive_low = force_lo
                      | (st == ST_RST  && ucnt < UCNT_W'(RST_LOW))
                      | (st == ST_SLOT && ucnt < low_units);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;  div_q <= DIV_W'(DIV_INIT);  dcnt <= '0;  ucnt <= '0;
      rst_pend <= 1'b0;  sra <= 1'b0;  force_lo <= 1'b0;  dq_s <= 1'b1;  smp <= 1'b1;
      pd <= 1'b0;  pdr <= 1'b0;  tbe <= 1'b1;  temt <= 1'b1;  rbf <= 1'b0;
      txbuf <= '0;  shreg <= '0;  rxsh <= '0;  rxbuf <= '0;  bitn <= '0;  ien <= '0;
    end else begin
      dq_s <= dq_in;
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) ucnt <= ucnt + 1'b1;
      if (rd_stat) pd  <= 1'b0;
      if (rd_data) rbf <= 1'b0;

      case (st)
        ST_IDLE: begin
          if (rst_pend) begin
            st <= ST_RST;  ucnt <= '0;  dcnt <= '0;
          end else if (!tbe) begin
            st <= ST_SLOT;  ucnt <= '0;  dcnt <= '0;
            shreg <= txbuf;  tbe <= 1'b1;  temt <= 1'b0;  bitn <= '0;
          end
        end
        ST_RST: if (tick) begin
          if (ucnt == UCNT_W'(RST_LOW + PD_AT - 1)) pdr <= !dq_s;
          if (ucnt == UCNT_W'(RST_LEN - 1)) begin
            st <= ST_IDLE;  rst_pend <= 1'b0;  pd <= 1'b1;
          end
        end
        ST_SLOT: if (tick) begin
          if (ucnt == UCNT_W'(SAMPLE_AT - 1)) smp <= dq_s;
          if (ucnt == UCNT_W'(SLOT_LEN - 1)) begin
            ucnt  <= '0;
            rxsh  <= {smp, rxsh[DATA_W-1:1]};
            shreg <= shreg >> 1;
            bitn  <= bitn + 1'b1;
            if (bitn == BIT_W'(DATA_W - 1)) begin
              st <= ST_IDLE;  rxbuf <= {smp, rxsh[DATA_W-1:1]};  rbf <= 1'b1;  temt <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (wr_cmd) begin
        if (bus_wdata[0]) rst_pend <= 1'b1;
        sra      <= bus_wdata[1];
        force_lo <= bus_wdata[2];
      end
      if (wr_data) begin
        txbuf <= bus_wdata;
        tbe   <= 1'b0;
      end
      if (wr_ien) ien   <= bus_wdata[NFLAG-1:0];
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CMD:   bus_rdata = DATA_W'({dq_s, 1'b0, sra, rst_pend});
      A_DATA:  bus_rdata = rxbuf;
      A_STAT:  bus_rdata = DATA_W'(stat);
      A_IEN:   bus_rdata = DATA_W'(ien);
      A_DIV:   bus_rdata = DATA_W'(div_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/owire_master_chk.sv
`timescale 1ns/1ps
module owire_master_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int UCNT_W = 10,
  parameter int W0_LOW = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              dq_drive_low,
  input logic              tbe,
  input logic              temt,
  input logic              rbf,
  input logic              pd,
  input logic              rst_pend,
  input logic              force_lo,
  input logic [1:0]        st,
  input logic [UCNT_W-1:0] ucnt
);
  assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[2]) |=> dq_drive_low);

  assert_tbe_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> !tbe);

  assert_reset_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pend) |-> pd);

  assert_rx_with_temt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbf) |-> temt);

  assert_slot_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && ucnt >= UCNT_W'(W0_LOW) && !force_lo) |-> !dq_drive_low);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[4:0] == 5'd0) |=> !irq);
endmodule

bind owire_master owire_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UCNT_W(UCNT_W), .W0_LOW(W0_LOW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq(irq), .dq_drive_low(dq_drive_low), .tbe(tbe), .temt(temt), .rbf(rbf), .pd(pd),
  .rst_pend(rst_pend), .force_lo(force_lo), .st(st), .ucnt(ucnt)
);

// File: tb/owire_master_tb_top.sv
`timescale 1ns/1ps
module owire_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, dq_drive_low, dq_in;
  logic       pres_low = 1'b0, rd_low = 1'b0;

  always #2.5 clk = ~clk;
  assign dq_in = !(dq_drive_low | pres_low | rd_low);

  owire_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dq_in(dq_in), .dq_drive_low(dq_drive_low)
  );

  int    n_chk = 0, n_fail = 0;
  int    d1 = 2;
  bit    exp_q[$];
  bit    force_exp = 1'b0;
  bit    mon_on = 1'b0;
  bit    line_exp;
  string cur_req = "R1";
  bit    pres_on = 1'b0, rd_on = 1'b0;
  logic [15:0] slave_word = 16'hFFFF;
  int    rd_idx = 0;
  logic [7:0] d;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp_v, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // per-cycle reference for the bus line
  always @(negedge clk) begin
    if (mon_on) begin
      line_exp = force_exp;
      if (exp_q.size() > 0) line_exp = line_exp | exp_q.pop_front();
      check(cur_req, "bus line", {31'd0, dq_drive_low}, {31'd0, line_exp});
    end
  end

  // slave presence pulse: 20..170 units after the reset low ends
  initial forever begin
    @(posedge dq_drive_low);
    if (pres_on) begin
      @(negedge dq_drive_low);
      repeat (20 * d1) @(posedge clk);
      pres_low = 1'b1;
      repeat (150 * d1) @(posedge clk);
      pres_low = 1'b0;
    end
  end

  // slave read response: pulls low for 30 units on its zero bits
  initial forever begin
    @(posedge dq_drive_low);
    if (rd_on) begin
      if (!slave_word[rd_idx]) begin
        rd_low = 1'b1;
        repeat (30 * d1) @(posedge clk);
        rd_low = 1'b0;
      end
      rd_idx++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 to R12: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic push_reset();
    exp_q.push_back(1'b0);
    repeat (480 * d1) exp_q.push_back(1'b1);
    repeat (480 * d1) exp_q.push_back(1'b0);
  endtask

  task automatic push_byte(input logic [7:0] b);
    exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) begin
      int lo = b[i] ? 6 : 60;
      repeat (lo * d1) exp_q.push_back(1'b1);
      repeat ((70 - lo) * d1) exp_q.push_back(1'b0);
    end
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; mon_on = 1'b1;

    // R1 / R12 reset state and map
    rd(3'd2, d); check("R1", "status", d, 8'h0C);
    rd(3'd0, d); check("R1", "command", d, 8'h08);
    rd(3'd3, d); check("R1", "enable", d, 8'h00);
    rd(3'd4, d); check("R1", "divisor", d, 8'h01);
    rd(3'd1, d); check("R12", "data", d, 8'h00);
    rd(3'd5, d); check("R12", "unmapped", d, 8'h00);
    check("R1", "irq", {31'd0, irq}, 32'd0);

    // R11 search flag latches only
    cur_req = "R11";
    wr(3'd0, 8'h02);
    rd(3'd0, d); check("R11", "search flag", d, 8'h0A);
    wr(3'd0, 8'h00);
    rd(3'd0, d); check("R11", "search flag off", d, 8'h08);

    // R9 / R10 forced low
    cur_req = "R9";
    wr(3'd0, 8'h04); force_exp = 1'b1;
    rd(3'd0, d); check("R10", "level one cycle late", d, 8'h08);
    rd(3'd0, d); check("R9", "force reads 0, level low", d, 8'h00);
    wr(3'd0, 8'h00); force_exp = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd0, d); check("R10", "level back high", d, 8'h08);

    // R3 / R4 reset with presence
    cur_req = "R3"; pres_on = 1'b1;
    wr(3'd0, 8'h01); push_reset();
    repeat (100) @(negedge clk);
    rd(3'd0, d); check("R3", "reset pending", d, 8'h01);
    wait_idle();
    rd(3'd2, d); check("R4", "presence seen", d, 8'h0F);
    rd(3'd2, d); check("R4", "done cleared by read", d, 8'h0E);
    rd(3'd0, d); check("R3", "reset bit cleared", d, 8'h08);
    pres_on = 1'b0;

    // R4 no presence
    wr(3'd0, 8'h01); push_reset(); wait_idle();
    rd(3'd2, d); check("R4", "no presence", d, 8'h0D);
    rd(3'd2, d); check("R4", "cleared", d, 8'h0C);

    // R2 divisor 3
    cur_req = "R2";
    wr(3'd4, 8'h03); d1 = 4;
    rd(3'd4, d); check("R2", "divisor readback", d, 8'h03);
    wr(3'd0, 8'h01); push_reset(); wait_idle();
    rd(3'd2, d); check("R2", "slow reset done", d, 8'h0D);
    wr(3'd4, 8'h01); d1 = 2;

    // R5 / R6 / R7 single byte, own line echo
    cur_req = "R5";
    wr(3'd1, 8'h3C); push_byte(8'h3C);
    rd(3'd2, d); check("R6", "buffer full", d, 8'h08);
    rd(3'd2, d); check("R6", "moved to shifter", d, 8'h04);
    wait_idle();
    rd(3'd2, d); check("R7", "receive full", d, 8'h1C);
    rd(3'd1, d); check("R7", "echo byte", d, 8'h3C);
    rd(3'd2, d); check("R7", "receive cleared", d, 8'h0C);

    // R7 / R8 slave read, queued second byte
    wr(3'd3, 8'h10);
    check("R8", "irq idle", {31'd0, irq}, 32'd0);
    slave_word = 16'hFFA5; rd_idx = 0; rd_on = 1'b1;
    wr(3'd1, 8'hFF); push_byte(8'hFF);
    repeat (10) @(negedge clk);
    wr(3'd1, 8'h81); push_byte(8'h81);
    rd(3'd2, d); check("R6", "both busy", d, 8'h00);
    while (!irq) @(negedge clk);
    rd(3'd1, d); check("R7", "slave byte", d, 8'hA5);
    check("R8", "irq after read", {31'd0, irq}, 32'd0);
    wait_idle();
    check("R8", "irq on receive", {31'd0, irq}, 32'd1);
    wr(3'd3, 8'h00);
    check("R8", "irq masked", {31'd0, irq}, 32'd0);
    rd(3'd1, d); check("R7", "second byte", d, 8'h81);
    rd(3'd2, d); check("R6", "all idle", d, 8'h0C);
    wr(3'd3, 8'h04);
    check("R8", "irq on buffer empty", {31'd0, irq}, 32'd1);
    wr(3'd3, 8'h00);
    rd_on = 1'b0;

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule